// File: doc/BRIEF.md
# Triggered Delayed One-Shot Pulse Timer

This block is a 16-bit timer that produces one delayed pulse for each accepted trigger. When it is enabled, its counter sits parked at all ones and waits. A trigger can be a chosen edge on an external input, passed through a two-flop synchroniser, or a software strobe. When a trigger is accepted, the counter restarts from zero and then advances on every cycle where the count-clock enable is high. The output turns active once the counter reaches the second compare value. It goes inactive again after the counter passes the first compare value. At that point the counter parks at all ones again and the timer waits for the next trigger.

The pulse is defined by two compare values. The delay before the pulse is `cmp1` count periods. The pulse width is `cmp0 - cmp1 + 1` count periods. Both values are captured into shadow copies when a trigger is accepted, so software can prepare the next shot while the current one is still running. A one-cycle interrupt strobe fires on each compare match. Any trigger that arrives while a shot is running is dropped. Clearing the enable stops everything at once.

Top module: `oneshot_delay_timer`

## Requirements
- R1: After reset the counter is parked, `pulse_out` equals `out_active_low` (the inactive level), and both interrupt strobes are low.
- R2: While `enable` is low, no trigger starts a shot, and the output stays inactive with no strobes. Dropping `enable` during a shot aborts it by the next clock, and no trigger seen while disabled is remembered afterwards.
- R3: When `sw_trig` is high on a clock edge while enabled and idle, a shot starts on that edge with the counter at zero.
- R4: `edge_sel` picks the external trigger. Code 0 is a rising edge, 1 is a falling edge, 2 is either edge, and 3 turns the external trigger off. A qualifying change on `trig_in` starts the shot on the third clock edge after the change is presented.
- R5: During a shot the counter advances only on edges where `tick` is high. It holds its value otherwise.
- R6: After a trigger the output stays inactive for exactly `cmp1` ticks.
- R7: The output is active for exactly `cmp0 - cmp1 + 1` ticks. The shot then ends and the counter parks at all ones.
- R8: A trigger of either kind that arrives during a shot has no effect, including one in the cycle of the shot's final tick.
- R9: `irq_cc0` is high for one cycle: the tick cycle in which the counter equals the captured `cmp0`, which is the final tick of the shot. `irq_cc1` is high for the tick cycle in which the counter equals the captured `cmp1`, which is the first active tick.
- R10: If `cmp1 > cmp0`, the shot produces no active level and no `irq_cc1`. It still ends after `cmp0 + 1` ticks with `irq_cc0`.
- R11: The compare values are captured when a trigger is accepted. Writes made during a shot apply only to the next shot.
- R12: `out_active_low` = 1 inverts `pulse_out`, so the inactive level is high and the active level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-clock enable |
| enable | input | 1 | Timer enable; low forces idle |
| cmp0_wr | input | 1 | Write strobe for the end compare value |
| cmp1_wr | input | 1 | Write strobe for the delay compare value |
| cmp_wdata | input | CNT_W | Compare write data |
| edge_sel | input | 2 | External edge select (0 rise, 1 fall, 2 both, 3 off) |
| out_active_low | input | 1 | Output polarity select |
| trig_in | input | 1 | Asynchronous external trigger |
| sw_trig | input | 1 | Software trigger strobe |
| pulse_out | output | 1 | One-shot pulse output |
| irq_cc0 | output | 1 | Match strobe for the end compare value |
| irq_cc1 | output | 1 | Match strobe for the delay compare value |

## Verification
Some properties are checked by assertions on every cycle:
- a software start loads zero;
- the count holds without `tick` and steps by one with it;
- the end strobe parks the counter;
- the captured end value stays fixed for the whole shot;
- a disabled timer stays quiet;
- the idle output sits at the polarity level.

Other properties need the bench's scenarios, which measure whole shots: the delay and width in ticks, where the strobes fall within the shot, the reversed-compare case, triggers dropped at the shot's final tick, the three-edge latency of each edge mode, and the deferred effect of writes made during a shot.

// File: rtl/osdt_pkg.sv
package osdt_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_NONE = 2'd3
   } edge_mode_e;

   localparam int NUM_CMP = 2;

   function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prev);
      logic hit;
      case (mode)
         EDGE_RISE: hit = cur & ~prev;
         EDGE_FALL: hit = ~cur & prev;
         EDGE_BOTH: hit = cur ^ prev;
         default:   hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/osdt_trig_sync.sv
module osdt_trig_sync
   import osdt_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_in,
   input  logic [1:0] edge_sel,
   output logic       ext_evt
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   // the edge history keeps tracking while disabled, so re-enabling never
   // sees a stale edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], trig_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign ext_evt = edge_hit(edge_mode_e'(edge_sel), sync_q[STAGES-1], prev_q);

endmodule

// File: rtl/osdt_cmp_bank.sv
module osdt_cmp_bank #(
   parameter int W   = 16,
   parameter int NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          wr_en,
   input  logic [W-1:0]            wr_data,
   input  logic                    capture,
   output logic [NCH-1:0][W-1:0]   shadow
);

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [W-1:0] prog_q;
      logic [W-1:0] shad_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prog_q <= '0;
            shad_q <= '0;
         end else begin
            if (wr_en[ch]) prog_q <= wr_data;
            // capture uses the value held before any same-cycle write
            if (capture)   shad_q <= prog_q;
         end
      end

      assign shadow[ch] = shad_q;
   end

endmodule

// File: rtl/osdt_shot_core.sv
module osdt_shot_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         enable,
   input  logic         start_req,
   input  logic [W-1:0] end_val,
   input  logic [W-1:0] dly_val,
   output logic [W-1:0] cnt_q,
   output logic         run_q,
   output logic         capture,
   output logic         hit_end,
   output logic         hit_dly,
   output logic         active
);

   localparam logic [W-1:0] PARK = '1;

   logic at_end;
   logic at_dly;

   assign at_end  = (cnt_q == end_val);
   assign at_dly  = (cnt_q == dly_val);
   assign capture = enable & ~run_q & start_req;
   assign hit_end = run_q & tick & at_end;
   assign hit_dly = run_q & tick & at_dly;
   assign active  = run_q & (cnt_q >= dly_val) & (cnt_q <= end_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= PARK;
         run_q <= 1'b0;
      end else if (!enable) begin
         cnt_q <= PARK;
         run_q <= 1'b0;
      end else if (capture) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q && tick) begin
         if (at_end) begin
            cnt_q <= PARK;
            run_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/oneshot_delay_timer.sv
module oneshot_delay_timer
   import osdt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic             cmp0_wr,
   input  logic             cmp1_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic [1:0]       edge_sel,
   input  logic             out_active_low,
   input  logic             trig_in,
   input  logic             sw_trig,
   output logic             pulse_out,
   output logic             irq_cc0,
   output logic             irq_cc1
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("oneshot_delay_timer: CNT_W must be 2..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("oneshot_delay_timer: SYNC_STAGES must be at least 2");
   end

   logic                          ext_evt;
   logic                          start_req;
   logic                          capture;
   logic                          run_q;
   logic                          act;
   logic [CNT_W-1:0]              cnt_q;
   logic [NUM_CMP-1:0][CNT_W-1:0] shadow;

   osdt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .edge_sel (edge_sel),
      .ext_evt  (ext_evt)
   );

   assign start_req = sw_trig | ext_evt;

   osdt_cmp_bank #(.W(CNT_W), .NCH(NUM_CMP)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   ({cmp1_wr, cmp0_wr}),
      .wr_data (cmp_wdata),
      .capture (capture),
      .shadow  (shadow)
   );

   osdt_shot_core #(.W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .enable    (enable),
      .start_req (start_req),
      .end_val   (shadow[0]),
      .dly_val   (shadow[1]),
      .cnt_q     (cnt_q),
      .run_q     (run_q),
      .capture   (capture),
      .hit_end   (irq_cc0),
      .hit_dly   (irq_cc1),
      .active    (act)
   );

   assign pulse_out = act ^ out_active_low;

endmodule

// File: rtl/osdt_checker.sv
module osdt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             tick,
   input logic             sw_trig,
   input logic             out_active_low,
   input logic             pulse_out,
   input logic             irq_cc0,
   input logic             irq_cc1,
   input logic             running,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] end_shadow
);

   assert_sw_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_trig && enable && !running) |=> (running && cnt == '0));

   assert_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && enable && !tick) |=> (running && $stable(cnt)));

   assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && enable && tick && !irq_cc0) |=> (running && cnt == $past(cnt) + 1'b1));

   assert_end_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_cc0 && enable) |=> (!running && cnt == '1));

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (running && enable && !irq_cc0) |=> running);

   assert_shadow_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (running && enable) |=> $stable(end_shadow));

   assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (pulse_out == out_active_low && !irq_cc0 && !irq_cc1));

   assert_idle_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (pulse_out == out_active_low && !irq_cc0 && !irq_cc1));

endmodule

bind oneshot_delay_timer osdt_checker #(.CNT_W(CNT_W)) u_osdt_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enable         (enable),
   .tick           (tick),
   .sw_trig        (sw_trig),
   .out_active_low (out_active_low),
   .pulse_out      (pulse_out),
   .irq_cc0        (irq_cc0),
   .irq_cc1        (irq_cc1),
   .running        (run_q),
   .cnt            (cnt_q),
   .end_shadow     (shadow[0])
);

// File: tb/oneshot_delay_timer_test.sv
`timescale 1ns/100ps
module oneshot_delay_timer_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         enable = 1'b0;
   logic         cmp0_wr = 1'b0;
   logic         cmp1_wr = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic [1:0]   edge_sel = 2'd0;
   logic         out_active_low = 1'b0;
   logic         trig_in = 1'b0;
   logic         sw_trig = 1'b0;
   logic         pulse_out;
   logic         irq_cc0;
   logic         irq_cc1;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   oneshot_delay_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
      .cmp0_wr(cmp0_wr), .cmp1_wr(cmp1_wr), .cmp_wdata(cmp_wdata),
      .edge_sel(edge_sel), .out_active_low(out_active_low),
      .trig_in(trig_in), .sw_trig(sw_trig),
      .pulse_out(pulse_out), .irq_cc0(irq_cc0), .irq_cc1(irq_cc1)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- requirement model ----------------
   function automatic logic exp_edge(logic [1:0] sel, logic cur, logic prev);
      case (sel)
         2'd0:    return cur & ~prev;
         2'd1:    return ~cur & prev;
         2'd2:    return cur ^ prev;
         default: return 1'b0;
      endcase
   endfunction

   logic         m_run = 1'b0;
   logic [W-1:0] m_t = '1, m_e = '0, m_d = '0, m_pe = '0, m_pd = '0;
   logic         m_s0 = 1'b0, m_s1 = 1'b0, m_prev = 1'b0;

   function automatic logic exp_active();
      return m_run && (m_t >= m_d) && (m_t <= m_e);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run <= 1'b0; m_t <= '1; m_e <= '0; m_d <= '0; m_pe <= '0; m_pd <= '0;
         m_s0 <= 1'b0; m_s1 <= 1'b0; m_prev <= 1'b0;
      end else begin
         if (cmp0_wr) m_pe <= cmp_wdata;
         if (cmp1_wr) m_pd <= cmp_wdata;
         m_s0 <= trig_in; m_s1 <= m_s0; m_prev <= m_s1;
         if (!enable) begin
            m_run <= 1'b0; m_t <= '1;
         end else if (!m_run && (sw_trig || exp_edge(edge_sel, m_s1, m_prev))) begin
            m_run <= 1'b1; m_t <= '0; m_e <= m_pe; m_d <= m_pd;
         end else if (m_run && tick) begin
            if (m_t == m_e) begin m_run <= 1'b0; m_t <= '1; end
            else m_t <= m_t + 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk("R5 R6 R7 R12 model pulse", pulse_out, exp_active() ^ out_active_low);
         chk("R9 model irq_cc0", irq_cc0, m_run && tick && (m_t == m_e));
         chk("R9 model irq_cc1", irq_cc1, m_run && tick && (m_t == m_d));
      end
   end

   // ---------------- directed helpers ----------------
   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_cmp(int e, int d);
      @(negedge clk); cmp0_wr = 1'b1; cmp_wdata = W'(e);
      @(negedge clk); cmp0_wr = 1'b0; cmp1_wr = 1'b1; cmp_wdata = W'(d);
      @(negedge clk); cmp1_wr = 1'b0;
   endtask

   task automatic shot_sw(string lbl, int e, int d, bit retrig, bit mid_wr, int ne, int nd);
      int first = 0, last = 0, i1 = 0, i0 = 0, n0 = 0;
      logic act;
      tick = 1'b1; enable = 1'b1;
      @(negedge clk); sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
      for (int j = 1; j <= e + 4; j++) begin
         #1;
         act = pulse_out ^ out_active_low;
         if (act) begin if (first == 0) first = j; last = j; end
         if (irq_cc1) i1 = j;
         if (irq_cc0) begin i0 = j; n0++; end
         sw_trig = retrig && (j == 2 || j == e + 1);
         cmp0_wr = mid_wr && (j == 1);
         cmp1_wr = mid_wr && (j == 2);
         cmp_wdata = (j == 1) ? W'(ne) : W'(nd);
         @(negedge clk);
      end
      sw_trig = 1'b0; cmp0_wr = 1'b0; cmp1_wr = 1'b0;
      if (d <= e) begin
         chk({lbl, " R6 delay ticks"}, first - 1, d);
         chk({lbl, " R7 active ticks"}, last - first + 1, e - d + 1);
         chk({lbl, " R9 irq_cc1 position"}, i1, d + 1);
      end else begin
         chk({lbl, " R10 no active level"}, first, 0);
         chk({lbl, " R10 no irq_cc1"}, i1, 0);
      end
      chk({lbl, " R9 irq_cc0 position"}, i0, e + 1);
      chk({lbl, " R9 irq_cc0 count"}, n0, 1);
   endtask

   task automatic edge_probe(string lbl, logic lvl, bit expect_start);
      @(negedge clk); trig_in = lvl;
      @(negedge clk); #1; chk({lbl, " R4 edge+1 idle"}, pulse_out ^ out_active_low, 0);
      @(negedge clk); #1; chk({lbl, " R4 edge+2 idle"}, pulse_out ^ out_active_low, 0);
      @(negedge clk); #1; chk({lbl, " R4 edge+3 start"}, pulse_out ^ out_active_low, expect_start);
      wait_cyc(8);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      void'($urandom(32'd20240611));
      wait_cyc(4);
      rst_n = 1'b1;
      #1;
      chk("R1 reset pulse_out", pulse_out, 0);
      chk("R1 reset irq_cc0", irq_cc0, 0);
      chk("R1 reset irq_cc1", irq_cc1, 0);

      wr_cmp(4, 0);  shot_sw("R3", 4, 0, 0, 0, 0, 0);
      wr_cmp(9, 3);  shot_sw("R6", 9, 3, 0, 0, 0, 0);
      wr_cmp(4, 4);  shot_sw("R7", 4, 4, 0, 0, 0, 0);
      wr_cmp(7, 2);  shot_sw("R8", 7, 2, 1, 0, 0, 0);
      wr_cmp(3, 6);  shot_sw("R10", 3, 6, 0, 0, 0, 0);
      wr_cmp(8, 4);  shot_sw("R11 old", 8, 4, 0, 1, 5, 1);
      shot_sw("R11 new", 5, 1, 0, 0, 0, 0);

      // R12: inverted polarity
      out_active_low = 1'b1;
      @(negedge clk); #1;
      chk("R12 idle level high", pulse_out, 1);
      wr_cmp(3, 1);  shot_sw("R12", 3, 1, 0, 0, 0, 0);
      out_active_low = 1'b0;

      // R5: counter frozen without tick
      wr_cmp(0, 0);
      @(negedge clk); tick = 1'b0; sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
      for (int j = 0; j < 10; j++) begin
         #1; chk("R5 held active without tick", pulse_out, 1);
         @(negedge clk);
      end
      tick = 1'b1; #1;
      chk("R5 R9 first tick ends shot", irq_cc0, 1);
      @(negedge clk); #1;
      chk("R5 R7 idle after tick", pulse_out, 0);

      // R2: disabled timer ignores triggers, disable aborts
      wr_cmp(10, 0);
      @(negedge clk); enable = 1'b0; edge_sel = 2'd0; sw_trig = 1'b1; trig_in = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
      for (int j = 0; j < 8; j++) begin
         #1; chk("R2 disabled no pulse", pulse_out, 0);
         chk("R2 disabled no irq", irq_cc0 | irq_cc1, 0);
         @(negedge clk);
      end
      enable = 1'b1;
      for (int j = 0; j < 4; j++) begin
         #1; chk("R2 no stale trigger after enable", pulse_out, 0);
         @(negedge clk);
      end
      trig_in = 1'b0; wait_cyc(6);
      sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
      wait_cyc(3); #1;
      chk("R2 shot running before abort", pulse_out, 1);
      enable = 1'b0;
      @(negedge clk); #1;
      chk("R2 abort on disable", pulse_out, 0);
      wait_cyc(2); enable = 1'b1;
      for (int j = 0; j < 12; j++) begin
         #1; chk("R2 aborted shot stays idle", pulse_out, 0);
         @(negedge clk);
      end

      // R4: edge modes
      wr_cmp(2, 0);
      for (int s = 0; s < 4; s++) begin
         edge_sel = 2'(s);
         wait_cyc(4);
         edge_probe("rise", 1'b1, (s == 0) || (s == 2));
         edge_probe("fall", 1'b0, (s == 1) || (s == 2));
      end

      // constrained random traffic, checked by the model
      edge_sel = 2'd2;
      for (int c = 0; c < 20000; c++) begin
         @(negedge clk);
         tick    = ($urandom % 4) != 0;
         sw_trig = ($urandom % 20) == 0;
         if (($urandom % 8) == 0) trig_in = ~trig_in;
         if (($urandom % 200) == 0) edge_sel = 2'($urandom % 4);
         if (($urandom % 300) == 0) out_active_low = ~out_active_low;
         enable  = ($urandom % 150) != 0;
         cmp0_wr = ($urandom % 10) == 0;
         cmp1_wr = ($urandom % 10) == 0;
         cmp_wdata = W'($urandom % 24);
      end
      @(negedge clk);
      cmp0_wr = 1'b0; cmp1_wr = 1'b0; sw_trig = 1'b0;
      wait_cyc(4);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL watchdog expired before completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule